// File: doc/BRIEF.md
# SPI Host Controller

This block is a serial-peripheral-interface master driven by a host through a small register port. The host writes control, clock-divider and data words, polls a status word, and reads received words back from the same data location it writes. One write to the data location launches the exchange of a single word. Outgoing bits leave MSB first on the serial data output while incoming bits are captured from the serial data input. Chip select is not part of the block; the host drives it elsewhere.

The serial clock runs at the core clock divided by 2×(divider+1). All four combinations of idle level and phase are available. A separate control bit moves the input capture point from the middle of each bit to its end. In single-buffer mode, one word can wait to be sent and one received word can be held. Enhanced mode turns both into queues of four words. Clearing the run bit halts the shifter and discards every queued and received word.

Top module: `spi_host_ctrl`

## Requirements
- R1: With divider value B in register index 3, each serial clock half period lasts B+1 core cycles. The first half period starts one cycle after the data write. The receive flag therefore appears 1+2·N·(B+1) cycles after the write clock edge, where N is the word length.
- R2: While no word is shifting, the serial clock rests at the idle level given by control bit 1 (0 low, 1 high). Each word produces exactly 2·N serial clock transitions, counting the final return to idle.
- R3: Control bit 2 selects the phase. With it clear, the clock holds its idle level for the first half bit. With it set, the clock leaves idle at the start of the first half bit. Modes 1 and 3 have bit 2 set; modes 2 and 3 have bit 1 set.
- R4: Control bit 3 selects the capture point. When it is 0, the input is captured in the last core cycle of the first half of each bit. When it is 1, the input is captured in the last core cycle of the second half.
- R5: Data leaves MSB first. Control bit 5 sets the word length: 0 gives 8 bits taken from write bits 7:0, and 1 gives 16 bits. The received word is returned in bits N-1:0 with zeros above.
- R6: Status is read at register index 1. In single-buffer mode (control bit 4 clear), status bit 0 rises when a received word is held. A read of the data location (index 4) clears bit 0 and sets the empty flag, status bit 1.
- R7: In enhanced mode (control bit 4 set), the transmit and receive queues each hold four words. Status bit 1 drops as soon as one word is held, while bit 0 stays low until four are held. Words are returned in order, and queued writes are sent one after another.
- R8: When a word completes while the receive buffer or queue is full, the word is discarded and overflow status bit 2 is set. Bit 2 then stays set until a write to index 2 with bit 2 set. A write to index 2 with bit 2 clear leaves it unchanged.
- R9: Clearing control bit 0 (run) stops any word in progress, returns the clock to idle, empties both queues and clears overflow. Data writes made while the run bit is clear are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive data at index 4) |
| reg_addr | input | 3 | Register index: 0 control, 1 status, 2 status clear, 3 divider, 4 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 16-bit and 8-bit word lengths, an 8-bit divider and four-entry queues. It sweeps every combination of idle level, phase, capture point, word length, divider values 0 to 2 and two input sources. With the input looped back from the serial output, the data path is checked bit for bit. With the input tied to the serial clock, the received word shows directly which half bit was sampled. The small divider values keep every sweep point short, and the four-entry queues let the bench fill them, overflow them and drain them within a few hundred cycles.

// File: rtl/sphc_pkg.sv
package sphc_pkg;

   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      IDX_CTRL  = 3'd0,
      IDX_STAT  = 3'd1,
      IDX_STCLR = 3'd2,
      IDX_BAUD  = 3'd3,
      IDX_DATA  = 3'd4
   } reg_idx_e;

   // control word, run bit in position 0
   typedef struct packed {
      logic wide;
      logic fifo;
      logic late;
      logic phase;
      logic idle_hi;
      logic run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam int ST_RXFULL  = 0;
   localparam int ST_RXEMPTY = 1;
   localparam int ST_OVF     = 2;
   localparam int ST_BUSY    = 3;
   localparam int ST_TXFULL  = 4;

endpackage

// File: rtl/sphc_fifo.sv
module sphc_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         cap_one,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] rp_q, wp_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = cap_one ? !empty : (cnt_q == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = empty ? '0 : mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rp_q  <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= wdata;
   end

endmodule

// File: rtl/sphc_engine.sv
module sphc_engine
   import sphc_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8,
   parameter int DIV_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  ctrl_t             cfg,
   input  logic [DIV_W-1:0]  baud,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              miso,
   output logic              take,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              active,
   output logic              sck,
   output logic              mosi
);

   localparam int PH_W      = $clog2(2 * WORD_W);
   localparam int SHIFT_PAD = WORD_W - NARROW_W;
   localparam logic [PH_W-1:0] LAST_WIDE   = PH_W'(2 * WORD_W - 1);
   localparam logic [PH_W-1:0] LAST_NARROW = PH_W'(2 * NARROW_W - 1);

   logic              act_q;
   logic [DIV_W-1:0]  hcnt_q, div_q;
   logic [PH_W-1:0]   ph_q, last_q;
   logic [WORD_W-1:0] txsr_q, rxsr_q;
   logic              pol_q, pha_q, late_q;

   logic              end_half, samp;
   logic [WORD_W-1:0] rx_next;

   assign take     = enable && !act_q && start;
   assign end_half = act_q && (hcnt_q == div_q);
   assign samp     = end_half && (ph_q[0] == late_q);
   assign rx_next  = {rxsr_q[WORD_W-2:0], miso};
   assign done     = end_half && (ph_q == last_q);
   assign rx_word  = late_q ? rx_next : rxsr_q;
   assign active   = act_q;
   assign sck      = act_q ? (pol_q ^ pha_q ^ ph_q[0]) : cfg.idle_hi;
   assign mosi     = act_q && txsr_q[WORD_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hcnt_q <= '0;
         div_q  <= '0;
         ph_q   <= '0;
         last_q <= '0;
         txsr_q <= '0;
         rxsr_q <= '0;
         pol_q  <= 1'b0;
         pha_q  <= 1'b0;
         late_q <= 1'b0;
      end else if (!enable) begin
         act_q  <= 1'b0;
         hcnt_q <= '0;
         ph_q   <= '0;
      end else if (take) begin
         act_q  <= 1'b1;
         hcnt_q <= '0;
         ph_q   <= '0;
         div_q  <= baud;
         last_q <= cfg.wide ? LAST_WIDE : LAST_NARROW;
         pol_q  <= cfg.idle_hi;
         pha_q  <= cfg.phase;
         late_q <= cfg.late;
         txsr_q <= cfg.wide ? tx_word : (tx_word << SHIFT_PAD);
         rxsr_q <= '0;
      end else if (act_q) begin
         if (end_half) begin
            hcnt_q <= '0;
            ph_q   <= ph_q + 1'b1;
            if (ph_q[0]) txsr_q <= txsr_q << 1;
            if (done)    act_q  <= 1'b0;
         end else begin
            hcnt_q <= hcnt_q + 1'b1;
         end
         if (samp) rxsr_q <= rx_next;
      end
   end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import sphc_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int NARROW_W   = 8,
   parameter int DIV_W      = 8,
   parameter int FIFO_DEPTH = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        sck,
   output logic        mosi,
   input  logic        miso
);

   initial begin
      if (NARROW_W < 2 || NARROW_W >= WORD_W)
         $fatal(1, "NARROW_W must lie in 2..WORD_W-1");
      if (WORD_W > 31)
         $fatal(1, "WORD_W must be below 32");
      if (DIV_W < 1 || DIV_W > 31)
         $fatal(1, "DIV_W must lie in 1..31");
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
         $fatal(1, "FIFO_DEPTH must be a power of two of at least 2");
   end

   ctrl_t             ctrl_q;
   logic [DIV_W-1:0]  baud_q;
   logic              ovf_q;

   logic              wr_ctrl, wr_baud, wr_data, wr_clr, rd_data;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;
   logic              eng_take, eng_done, eng_active;
   logic [31:0]       stat_word;
   logic              unused_wdata;

   assign unused_wdata = ^reg_wdata[31:WORD_W];

   assign wr_ctrl = reg_wr && (reg_addr == IDX_CTRL);
   assign wr_baud = reg_wr && (reg_addr == IDX_BAUD);
   assign wr_data = reg_wr && (reg_addr == IDX_DATA) && ctrl_q.run;
   assign wr_clr  = reg_wr && (reg_addr == IDX_STCLR) && reg_wdata[ST_OVF];
   assign rd_data = reg_rd && (reg_addr == IDX_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         baud_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (wr_baud) baud_q <= reg_wdata[DIV_W-1:0];
      end
   end

   // overflow: a completing word meets a full receive store
   always_ff @(posedge clk) begin
      if (!rst_n || !ctrl_q.run)      ovf_q <= 1'b0;
      else if (eng_done && rx_full)   ovf_q <= 1'b1;
      else if (wr_clr)                ovf_q <= 1'b0;
   end

   sphc_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (!ctrl_q.run),
      .cap_one (!ctrl_q.fifo),
      .push    (wr_data),
      .wdata   (reg_wdata[WORD_W-1:0]),
      .pop     (eng_take),
      .rdata   (tx_head),
      .full    (tx_full),
      .empty   (tx_empty)
   );

   sphc_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (!ctrl_q.run),
      .cap_one (!ctrl_q.fifo),
      .push    (eng_done),
      .wdata   (rx_word),
      .pop     (rd_data),
      .rdata   (rx_head),
      .full    (rx_full),
      .empty   (rx_empty)
   );

   sphc_engine #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .DIV_W(DIV_W)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctrl_q.run),
      .cfg     (ctrl_q),
      .baud    (baud_q),
      .start   (!tx_empty),
      .tx_word (tx_head),
      .miso    (miso),
      .take    (eng_take),
      .done    (eng_done),
      .rx_word (rx_word),
      .active  (eng_active),
      .sck     (sck),
      .mosi    (mosi)
   );

   always_comb begin
      stat_word             = '0;
      stat_word[ST_RXFULL]  = rx_full;
      stat_word[ST_RXEMPTY] = rx_empty;
      stat_word[ST_OVF]     = ovf_q;
      stat_word[ST_BUSY]    = eng_active || !tx_empty;
      stat_word[ST_TXFULL]  = tx_full;
   end

   always_comb begin
      case (reg_addr)
         IDX_CTRL: reg_rdata = 32'(ctrl_q);
         IDX_STAT: reg_rdata = stat_word;
         IDX_BAUD: reg_rdata = 32'(baud_q);
         IDX_DATA: reg_rdata = 32'(rx_head);
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sphc_checker.sv
module sphc_checker
   import sphc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic [2:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic        sck,
   input logic        ctrl_run,
   input logic        ctrl_idle,
   input logic        ctrl_fifo,
   input logic        eng_active,
   input logic        eng_done,
   input logic        rx_full,
   input logic        rx_empty,
   input logic        ovf
);

   // R2: idle clock level follows the polarity control
   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_active |-> (sck == ctrl_idle));

   // R8: completion into a full store raises overflow
   p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && rx_full && ctrl_run) |=> ovf);

   // R8: overflow is sticky until a write-one clear
   p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && ctrl_run && !(reg_wr && reg_addr == IDX_STCLR && reg_wdata[ST_OVF])) |=> ovf);

   // R9: run cleared empties everything
   p_off_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_run |=> (rx_empty && !eng_active && !ovf));

   // R6: in single-buffer mode a data read empties the receive store
   p_pop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_run && !ctrl_fifo && !reg_wr && reg_rd && reg_addr == IDX_DATA && !rx_empty)
      |=> rx_empty);

endmodule

bind spi_host_ctrl sphc_checker u_sphc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .sck        (sck),
   .ctrl_run   (ctrl_q.run),
   .ctrl_idle  (ctrl_q.idle_hi),
   .ctrl_fifo  (ctrl_q.fifo),
   .eng_active (eng_active),
   .eng_done   (eng_done),
   .rx_full    (rx_full),
   .rx_empty   (rx_empty),
   .ovf        (ovf_q)
);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic        sck, mosi, miso;
   logic        miso_from_sck = 1'b0;

   int n_chk = 0;
   int n_err = 0;

   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CLR = 3'd2,
                          A_BAUD = 3'd3, A_DATA = 3'd4;

   always #10 clk = ~clk;

   assign miso = miso_from_sck ? sck : mosi;

   spi_host_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sck       (sck),
      .mosi      (mosi),
      .miso      (miso)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 32'd0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_stat(input int bitpos, input logic val, input int limit);
      reg_addr = A_STAT;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (reg_rdata[bitpos] == val) return;
      end
   endtask

   function automatic logic [31:0] ctrlw(bit run, bit pol, bit pha, bit late, bit fifo, bit wide);
      return {26'd0, wide, fifo, late, pha, pol, run};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int idx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(A_STAT, d);
      chk(d[4:0] == 5'b00010, "R6 reset status", d, 32'h2);
      chk(sck == 1'b0, "R2 reset idle", sck, 0);

      idx = 0;
      for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
      for (int late = 0; late < 2; late++)
      for (int wide = 0; wide < 2; wide++)
      for (int b = 0; b < 3; b++)
      for (int src = 0; src < 2; src++) begin
         logic [15:0] w;
         logic [31:0] mask, exp_rx;
         int nb, k, edges, exp_k;
         logic prev;
         bit lvl;
         nb = wide ? 16 : 8;
         mask = (32'd1 << nb) - 1;
         w = 16'h5A3C ^ 16'(idx * 16'h01B7);
         idx++;
         miso_from_sck = (src == 1);
         wr(A_CTRL, ctrlw(1, pol[0], pha[0], late[0], 0, wide[0]));
         wr(A_BAUD, 32'(b));
         chk(sck == pol[0], "R2 idle level", sck, pol);
         wr(A_DATA, {16'd0, w});
         reg_addr = A_STAT;
         k = 0; edges = 0; prev = sck;
         exp_k = 1 + 2 * nb * (b + 1);
         while (k < 200) begin
            @(negedge clk);
            k++;
            if (sck != prev) edges++;
            prev = sck;
            if (k == 1) begin
               chk(sck == (pol[0] ^ pha[0]), "R3 first half level", sck, pol ^ pha);
               chk(mosi == (wide ? w[15] : w[7]), "R5 MSB first", mosi, wide ? w[15] : w[7]);
            end
            if (reg_rdata[0]) break;
         end
         chk(k == exp_k, "R1 word duration", k, exp_k);
         chk(edges == 2 * nb, "R2 clock transitions", edges, 2 * nb);
         lvl = late[0] ? !(pol[0] ^ pha[0]) : (pol[0] ^ pha[0]);
         exp_rx = src ? (lvl ? mask : 32'd0) : (32'(w) & mask);
         rd(A_DATA, d);
         chk(d == exp_rx, src ? "R4 capture point" : "R5 loopback data", d, exp_rx);
         rd(A_STAT, d);
         chk(d[1:0] == 2'b10, "R6 read clears flag", d, 32'h2);
      end
      miso_from_sck = 1'b0;

      // single-buffer overflow
      wr(A_CTRL, ctrlw(1, 0, 0, 0, 0, 0));
      wr(A_BAUD, 0);
      wr(A_DATA, 32'h11);
      wait_stat(0, 1'b1, 100);
      wr(A_DATA, 32'h22);
      wait_stat(3, 1'b0, 100);
      rd(A_STAT, d);
      chk(d[2] == 1'b1, "R8 overflow single", d, 32'h4);
      rd(A_DATA, d);
      chk(d == 32'h11, "R8 discarded word", d, 32'h11);
      wr(A_CLR, 32'h0);
      rd(A_STAT, d);
      chk(d[2] == 1'b1, "R8 clear with zero", d, 32'h4);
      wr(A_CLR, 32'h4);
      rd(A_STAT, d);
      chk(d[2] == 1'b0, "R8 clear with one", d, 32'h0);

      // enhanced queues
      wr(A_CTRL, ctrlw(1, 0, 0, 0, 1, 0));
      wr(A_DATA, 32'hA1);
      wait_stat(1, 1'b0, 100);
      rd(A_STAT, d);
      chk(d[1:0] == 2'b00, "R7 empty drops first", d, 32'h0);
      wr(A_DATA, 32'hB2);
      wr(A_DATA, 32'hC3);
      wr(A_DATA, 32'hD4);
      wait_stat(0, 1'b1, 400);
      rd(A_STAT, d);
      chk(d[1:0] == 2'b01, "R7 queue full", d, 32'h1);
      wr(A_DATA, 32'hE5);
      wait_stat(3, 1'b0, 100);
      rd(A_STAT, d);
      chk(d[2] == 1'b1, "R8 overflow queue", d, 32'h4);
      for (int i = 0; i < 4; i++) begin
         logic [31:0] e;
         e = (i == 0) ? 32'hA1 : (i == 1) ? 32'hB2 : (i == 2) ? 32'hC3 : 32'hD4;
         rd(A_DATA, d);
         chk(d == e, "R7 queue order", d, e);
      end
      rd(A_STAT, d);
      chk(d[1] == 1'b1, "R7 drained", d, 32'h2);

      // run bit cleared: stop and flush
      wr(A_CTRL, ctrlw(1, 1, 0, 0, 0, 1));
      wr(A_BAUD, 5);
      wr(A_DATA, 32'h1234);
      repeat (10) @(negedge clk);
      wr(A_CTRL, ctrlw(0, 1, 0, 0, 0, 1));
      @(negedge clk);
      chk(sck == 1'b1, "R9 clock idle after stop", sck, 1);
      rd(A_STAT, d);
      chk(d[3:0] == 4'b0010, "R9 stopped status", d, 32'h2);
      wr(A_DATA, 32'h5555);
      wr(A_CTRL, ctrlw(1, 1, 0, 0, 0, 1));
      repeat (4) @(negedge clk);
      rd(A_STAT, d);
      chk(d[3:0] == 4'b0010, "R9 write while stopped ignored", d, 32'h2);
      wr(A_BAUD, 0);
      wr(A_DATA, 32'h00AA);
      wait_stat(0, 1'b1, 100);
      wr(A_DATA, 32'h00BB);
      wait_stat(3, 1'b0, 100);
      wr(A_CTRL, ctrlw(0, 1, 0, 0, 0, 1));
      wr(A_CTRL, ctrlw(1, 1, 0, 0, 0, 1));
      rd(A_STAT, d);
      chk(d[2:0] == 3'b010, "R9 flush clears data and overflow", d, 32'h2);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule